// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block turns an input event into one output pulse of a set length, counted in clock cycles. Each channel has three control inputs. The first is an active-low trigger that fires on its falling edge. The second is an active-high trigger that fires on its rising edge. The third is an active-low clear. Clear stops a running pulse, and its release can also start a pulse. Each channel drives a pulse output and a separately registered complement of it. The per-channel width input takes the place of a resistor-capacitor timing network.

All three inputs pass through two-flop synchronizers and are then edge-detected in the clock domain, so they may be driven from asynchronous sources. Once a pulse has started, its length is fixed, and trigger edges that arrive during it are discarded. Several identical channels sit side by side and share only the clock and reset. The block has no data stream, so it has no valid/ready interface: every pin is a plain level.

Top module: `mpg_oneshot`

## Requirements
- R1: A falling edge on `fall_trig_n` starts a pulse when `rise_trig` is high and `clear_n` is high.
- R2: A rising edge on `rise_trig` starts a pulse when `fall_trig_n` is low and `clear_n` is high.
- R3: A rising edge on `clear_n` starts a pulse only if `fall_trig_n` is low, `rise_trig` is high, and `rise_trig` rose while `clear_n` was low. Releasing clear without that earlier rise produces no pulse.
- R4: While the synchronized `clear_n` is low, `pulse` is low and `pulse_n` is high. A pulse that is running when clear is taken low stops on the cycle after the clear level has passed the synchronizer.
- R5: When a trigger edge and a low clear level reach the edge detector in the same cycle, clear takes priority and no pulse starts.
- R6: The block cannot be retriggered. Trigger edges that arrive while a pulse is high are ignored. The width value is captured when the pulse starts, so later changes to it do not alter that pulse.
- R7: `pulse` stays high for exactly `width_cycles` clock cycles. A width of 0 gives a pulse one cycle long.
- R8: If no qualifying edge occurs, `pulse` stays low. This covers `fall_trig_n` held high, `rise_trig` held low, or all inputs static.
- R9: In every cycle, `pulse_n` is the exact inverse of `pulse`.
- R10: The first clock edge that samples the input change is edge k. `pulse` goes high after edge k+2.
- R11: Channels are independent. Each channel uses only its own inputs and its own width slice.
- R12: While `rst_n` is low, each channel returns to idle: `pulse` low, `pulse_n` high, and the counter and the clear-release arming flag both cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_trig_n | input | NUM_CH | Active-low trigger, one bit per channel, fires on its falling edge |
| rise_trig | input | NUM_CH | Active-high trigger, one bit per channel, fires on its rising edge |
| clear_n | input | NUM_CH | Active-low clear per channel; its rising edge can also start a pulse |
| width_cycles | input | NUM_CH*WIDTH_W | Pulse width in cycles, one WIDTH_W slice per channel, channel 0 in the low bits |
| pulse | output | NUM_CH | Pulse output |
| pulse_n | output | NUM_CH | Complementary pulse output |

## Verification
The bound checker watches every cycle. It checks the following:
- `pulse_n` is always the complement of `pulse`.
- A synchronized low clear forces the output low.
- An accepted trigger on an idle channel raises the output.
- Every rising output has a qualified trigger behind it.
- Each uninterrupted pulse lasts exactly the width captured at its start, which also shows that mid-pulse triggers had no effect.

Some behaviours can only be shown by the bench's scenarios, because they are about the raw pins rather than the synchronized levels:
- the two-to-three cycle latency from pin to output
- the arming rule that lets a clear release start a pulse
- clear winning over a simultaneous trigger edge
- the silence of the output under static or unqualified inputs

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  // Synchronized control levels of one channel.
  typedef struct packed {
    logic fall_n;  // active-low trigger level
    logic rise;    // active-high trigger level
    logic clr_n;   // active-low clear level
  } mpg_lvl_t;

  localparam mpg_lvl_t MPG_IDLE = '{fall_n: 1'b1, rise: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/mpg_sync.sv
module mpg_sync #(
  parameter int          BITS    = 3,
  parameter logic [BITS-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  logic [BITS-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mpg_edge.sv
module mpg_edge
  import mpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mpg_lvl_t cur,
  output logic     trig
);
  mpg_lvl_t prev;
  logic     armed;
  logic     fall_ev, rise_ev, clr_ev;

  assign fall_ev = prev.fall_n & ~cur.fall_n;
  assign rise_ev = ~prev.rise & cur.rise;
  assign clr_ev  = ~prev.clr_n & cur.clr_n;

  // Clear low blocks every path; the clear-release path needs arming.
  assign trig = cur.clr_n & (
                  (fall_ev & cur.rise) |
                  (rise_ev & ~cur.fall_n) |
                  (clr_ev & ~cur.fall_n & cur.rise & armed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= MPG_IDLE;
      armed <= 1'b0;
    end else begin
      prev <= cur;
      if (!cur.rise)                armed <= 1'b0;
      else if (!cur.clr_n && rise_ev) armed <= 1'b1;
      else if (clr_ev)              armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mpg_timer.sv
module mpg_timer #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               clr_ok,
  input  logic [WIDTH_W-1:0] width,
  output logic               q,
  output logic               q_n
);
  logic [WIDTH_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || !clr_ok) begin
      q      <= 1'b0;
      q_n    <= 1'b1;
      remain <= '0;
    end else if (!q) begin
      if (trig) begin
        q      <= 1'b1;
        q_n    <= 1'b0;
        remain <= (width == '0) ? '0 : width - 1'b1;
      end
    end else if (remain == '0) begin
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/mpg_oneshot.sv
module mpg_oneshot
  import mpg_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int WIDTH_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         fall_trig_n,
  input  logic [NUM_CH-1:0]         rise_trig,
  input  logic [NUM_CH-1:0]         clear_n,
  input  logic [NUM_CH*WIDTH_W-1:0] width_cycles,
  output logic [NUM_CH-1:0]         pulse,
  output logic [NUM_CH-1:0]         pulse_n
);
  localparam int LVL_BITS = $bits(mpg_lvl_t);

  logic [NUM_CH-1:0] clr_s;
  logic [NUM_CH-1:0] trig_v;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    mpg_lvl_t raw, lvl;
    logic     p, pn;

    assign raw = '{fall_n: fall_trig_n[ch], rise: rise_trig[ch], clr_n: clear_n[ch]};

    mpg_sync #(.BITS(LVL_BITS), .RST_VAL(MPG_IDLE)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
    );

    mpg_edge i_edge (
      .clk(clk), .rst_n(rst_n), .cur(lvl), .trig(trig_v[ch])
    );

    mpg_timer #(.WIDTH_W(WIDTH_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .trig(trig_v[ch]), .clr_ok(lvl.clr_n),
      .width(width_cycles[ch*WIDTH_W +: WIDTH_W]), .q(p), .q_n(pn)
    );

    assign clr_s[ch]   = lvl.clr_n;
    assign pulse[ch]   = p;
    assign pulse_n[ch] = pn;
  end
endmodule

// File: rtl/mpg_oneshot_chk.sv
module mpg_oneshot_chk #(
  parameter int NUM_CH  = 2,
  parameter int WIDTH_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH-1:0]         clr_s,
  input logic [NUM_CH-1:0]         trig,
  input logic [NUM_CH*WIDTH_W-1:0] width_cycles,
  input logic [NUM_CH-1:0]         pulse,
  input logic [NUM_CH-1:0]         pulse_n
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    logic [WIDTH_W:0] seen, want;
    logic             cut;
    logic [WIDTH_W-1:0] w;
    assign w = width_cycles[ch*WIDTH_W +: WIDTH_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen <= '0;
        want <= '0;
        cut  <= 1'b0;
      end else begin
        if (!pulse[ch] && trig[ch] && clr_s[ch]) begin
          seen <= '0;
          want <= (w == '0) ? 1 : {1'b0, w};
          cut  <= 1'b0;
        end else begin
          if (pulse[ch]) seen <= seen + 1'b1;
          if (!clr_s[ch]) cut <= 1'b1;
        end
      end
    end

    assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_n[ch] == !pulse[ch]);

    // R4 and R5: a low clear level blocks and ends pulses.
    assert_clear_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s[ch] |=> !pulse[ch]);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse[ch] && trig[ch] && clr_s[ch]) |=> pulse[ch]);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[ch]) |-> $past(trig[ch]));

    // R6: mid-pulse triggers and width changes leave the length untouched.
    assert_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pulse[ch]) && !cut) |-> (seen == want));
  end
endmodule

bind mpg_oneshot mpg_oneshot_chk #(.NUM_CH(NUM_CH), .WIDTH_W(WIDTH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .trig(trig_v),
  .width_cycles(width_cycles), .pulse(pulse), .pulse_n(pulse_n)
);

// File: tb/test_mpg_oneshot.sv
module test_mpg_oneshot;
  localparam int NUM_CH  = 2;
  localparam int WIDTH_W = 8;

  typedef struct {
    int    t;
    int    w;
    string req;
  } exp_t;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic [NUM_CH-1:0]         fall_n = '1;
  logic [NUM_CH-1:0]         rise = '0;
  logic [NUM_CH-1:0]         clr = '1;
  logic [NUM_CH*WIDTH_W-1:0] width = '0;
  logic [NUM_CH-1:0]         pulse, pulse_n;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t q0[$];
  exp_t q1[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mpg_oneshot #(.NUM_CH(NUM_CH), .WIDTH_W(WIDTH_W)) i_mpg_oneshot (
    .clk(clk), .rst_n(rst_n), .fall_trig_n(fall_n), .rise_trig(rise),
    .clear_n(clr), .width_cycles(width), .pulse(pulse), .pulse_n(pulse_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int ch, input int t, input int w, input string req);
    exp_t e;
    e.t = t; e.w = (w == 0) ? 1 : w; e.req = req;
    if (ch == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_w(input int ch, input int w);
    width[ch*WIDTH_W +: WIDTH_W] = WIDTH_W'(w);
  endtask

  // Monitor: measures each pulse and compares it with the scoreboard.
  int   rise_t[NUM_CH];
  int   run_w[NUM_CH];
  logic prev_p[NUM_CH];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        check(pulse_n[ch] == !pulse[ch], "R9 complement", int'(pulse_n[ch]), int'(!pulse[ch]));
        if (pulse[ch] && !prev_p[ch]) begin
          rise_t[ch] = cyc;
          run_w[ch]  = 1;
        end else if (pulse[ch]) begin
          run_w[ch]++;
        end else if (prev_p[ch]) begin
          exp_t e;
          int   empty;
          empty = (ch == 0) ? (q0.size() == 0) : (q1.size() == 0);
          if (empty) begin
            check(1'b0, "R8 unexpected pulse", rise_t[ch], -1);
          end else begin
            e = (ch == 0) ? q0.pop_front() : q1.pop_front();
            check(rise_t[ch] == e.t, {e.req, " R10 start cycle"}, rise_t[ch], e.t);
            check(run_w[ch] == e.w, {e.req, " R7 width"}, run_w[ch], e.w);
          end
        end
        prev_p[ch] = pulse[ch];
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) prev_p[ch] = 1'b0;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    set_w(0, 5); set_w(1, 9);
    wait_n(5);
    // R12: idle state in and after reset
    check(pulse == '0, "R12 reset pulse", int'(pulse), 0);
    check(pulse_n == '1, "R12 reset pulse_n", int'(pulse_n), 3);
    rst_n = 1'b1;
    wait_n(4);
    check(pulse == '0, "R12 idle after reset", int'(pulse), 0);

    // R1: falling active-low trigger while rise_trig high
    rise[0] = 1'b1;  // rising edge with fall_n high: no pulse (R8)
    wait_n(10);
    check(pulse[0] == 1'b0, "R8 rise with fall_n high", int'(pulse[0]), 0);
    fall_n[0] = 1'b0; push(0, cyc + 3, 5, "R1");
    wait_n(15);

    // R2: rising active-high trigger while fall_n low
    rise[0] = 1'b0;
    wait_n(8);
    rise[0] = 1'b1; push(0, cyc + 3, 5, "R2");
    wait_n(15);

    // R6: retrigger and width change during a pulse are ignored
    set_w(0, 6);
    fall_n[0] = 1'b1;
    wait_n(8);
    fall_n[0] = 1'b0; push(0, cyc + 3, 6, "R6");
    wait_n(2); fall_n[0] = 1'b1;
    wait_n(1); fall_n[0] = 1'b0; set_w(0, 2);
    wait_n(20);

    // R7: width 0 and width 1 both give one cycle
    set_w(0, 0);
    fall_n[0] = 1'b1; wait_n(6);
    fall_n[0] = 1'b0; push(0, cyc + 3, 0, "R7 w0");
    wait_n(10);
    set_w(0, 1);
    fall_n[0] = 1'b1; wait_n(6);
    fall_n[0] = 1'b0; push(0, cyc + 3, 1, "R7 w1");
    wait_n(10);

    // R4: clear cuts a long pulse and holds the output low
    set_w(0, 20);
    fall_n[0] = 1'b1; wait_n(6);
    fall_n[0] = 1'b0; push(0, cyc + 3, 6, "R4 cut");
    wait_n(6);
    clr[0] = 1'b0;
    wait_n(5);
    for (int i = 0; i < 10; i++) begin
      check(pulse[0] == 1'b0 && pulse_n[0] == 1'b1, "R4 hold low", int'(pulse[0]), 0);
      wait_n(1);
    end
    // R3: release without an armed rise starts nothing
    clr[0] = 1'b1;
    wait_n(15);
    check(pulse[0] == 1'b0, "R3 unarmed release", int'(pulse[0]), 0);

    // R3: rise while clear low arms the release path
    set_w(0, 4);
    clr[0] = 1'b0; rise[0] = 1'b0; fall_n[0] = 1'b0;
    wait_n(6);
    rise[0] = 1'b1;
    wait_n(6);
    check(pulse[0] == 1'b0, "R4 rise during clear", int'(pulse[0]), 0);
    clr[0] = 1'b1; push(0, cyc + 3, 4, "R3 release");
    wait_n(15);

    // R5: trigger edge together with clear low
    fall_n[0] = 1'b1; rise[0] = 1'b1; clr[0] = 1'b1;
    wait_n(6);
    fall_n[0] = 1'b0; clr[0] = 1'b0;
    wait_n(10);
    check(pulse[0] == 1'b0, "R5 clear wins", int'(pulse[0]), 0);
    clr[0] = 1'b1;
    wait_n(15);
    check(pulse[0] == 1'b0, "R5 no late pulse", int'(pulse[0]), 0);

    // R8: fall_n held high while rise_trig toggles, then static inputs
    fall_n[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rise[0] = ~rise[0];
      wait_n(4);
    end
    wait_n(20);
    check(pulse == '0, "R8 static inputs", int'(pulse), 0);

    // R11: two channels with their own widths and timing
    set_w(0, 3); set_w(1, 9);
    rise = '1; fall_n = '1;
    wait_n(8);
    fall_n[0] = 1'b0; push(0, cyc + 3, 3, "R11 ch0");
    wait_n(2);
    fall_n[1] = 1'b0; push(1, cyc + 3, 9, "R11 ch1");
    wait_n(25);

    check(q0.size() == 0, "R6 missing pulses ch0", q0.size(), 0);
    check(q1.size() == 0, "R11 missing pulses ch1", q1.size(), 0);
    finish_run();
  end
endmodule